// File: doc/BRIEF.md
# Output Word Rounder with Dither and Saturation

This block takes a wide signed fixed-point sample from the end of an audio interpolation filter and reduces it to the word length that the serial output stage sends. The output word is either 24 or 20 bits. There are two ways to round the bits that are dropped. Plain rounding adds half an output LSB. Dithered rounding adds a pseudorandom value spread evenly over zero to one output LSB. The rounded value then passes through a limiter. The limiter pins any result that does not fit to the largest positive or largest negative code of the chosen length. This covers overflow caused by the rounding step and overflow already carried in the input's headroom bits.

The input has 34 bits: 2 bits of integer headroom, then 32 fraction-aligned bits. The top 24 of those 32 bits line up with a 24-bit output word. The pseudorandom source is a 23-bit maximal-length shift register inside the block. It steps once for every accepted sample and starts from a fixed seed after reset. One clock after a valid input, the block presents the word together with an output valid strobe.

Top module: `word_rounder`

## Requirements
- R1: `out_valid` is high in the cycle after each cycle in which `in_valid` is high, and low otherwise. `out_sample` changes only in the cycle after an accepted sample and holds its value in all other cycles.
- R2: While `rst` is high at a clock edge, the block does the following at that edge. It clears `out_valid` and `out_sample` to zero. It loads the shift register with the seed, 23'h4F1BD3 by default.
- R3: When `len_sel` is 1, the word is 24 bits and is formed from input bits [31:8]. When `len_sel` is 0, the word is 20 bits and is formed from input bits [31:12]. In 20-bit mode the word is placed in `out_sample[19:0]`, and bits [23:20] copy bit 19.
- R4: When `dith_en` is 0, the block adds half an output LSB (2^7 in 24-bit mode, 2^11 in 20-bit mode) to the signed input. It then drops the low bits with floor (arithmetic shift).
- R5: When `dith_en` is 1, the value added is the low 8 bits (24-bit mode) or the low 12 bits (20-bit mode) of the shift register state before that sample's step. This value is always between 0 and one output LSB minus one input step.
- R6: The shift register is 23 bits wide. Each step shifts it left by one and puts (bit 22 XOR bit 17) into bit 0. It steps once per accepted sample in both rounding modes, and it holds while `in_valid` is low.
- R7: A rounded result above the largest code of the selected length gives exactly that code: 24'h7FFFFF in 24-bit mode, or 20'h7FFFF sign-extended (24'h07FFFF) in 20-bit mode. A non-negative input never gives a negative output.
- R8: A rounded result below the most negative code of the selected length gives exactly that code: 24'h800000 in 24-bit mode, or 24'hF80000 in 20-bit mode. This includes inputs whose headroom bits show an earlier overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample qualifier |
| in_sample | input | 34 | Signed input: 2 headroom bits, then 32 aligned bits |
| len_sel | input | 1 | 1 = 24-bit word, 0 = 20-bit word |
| dith_en | input | 1 | 1 = dithered rounding, 0 = half-LSB rounding |
| out_valid | output | 1 | Output sample qualifier, one clock after input |
| out_sample | output | 24 | Rounded and limited word, sign-extended in 20-bit mode |

## Verification
The bench checks inputs that sit exactly on the half-LSB point, just below it and just above it, for both positive and negative values. A design that rounds toward zero, or truncates without adding the offset, gives an answer one code off on these inputs. It also drives values that only overflow once the offset is added, plus inputs whose headroom is full in either direction. A limiter that checks the wrong bits or compares at the wrong length would wrap these to the opposite sign. Long dithered runs with idle gaps, mixed with runs in plain mode, compare every word against a model of the shift register. A generator that steps on idle cycles, stops stepping in plain mode or takes the wrong taps goes out of step after a few samples.

// File: rtl/rounder_pkg.sv
package rounder_pkg;
  typedef enum logic {LEN_SHORT = 1'b0, LEN_LONG = 1'b1} len_e;

  function automatic int unsigned half_lsb_exp(input int unsigned drop);
    return drop - 1;
  endfunction
endpackage

// File: rtl/dither_lfsr.sv
module dither_lfsr #(
  parameter int W      = 23,
  parameter int TAP    = 18,
  parameter logic [W-1:0] SEED = 23'h4F1BD3,
  parameter int DOUT_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  output logic [DOUT_W-1:0] dout
);
  logic [W-1:0] state;
  logic         fb;

  assign fb   = state[W-1] ^ state[TAP-1];
  assign dout = state[DOUT_W-1:0];

  always_ff @(posedge clk) begin
    if (rst)      state <= SEED;
    else if (adv) state <= {state[W-2:0], fb};
  end

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (rst)
    state != '0);  // R6
  AST_LFSR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(state));  // R6
endmodule

// File: rtl/round_sat.sv
module round_sat #(
  parameter int IN_W  = 34,
  parameter int DROP  = 8,
  parameter int KEEP  = 24,
  parameter int OUT_W = 24
) (
  input  logic [IN_W-1:0]  din,
  input  logic [DROP-1:0]  radd,
  output logic [OUT_W-1:0] q
);
  localparam int SUM_W = IN_W + 1;
  localparam int HI_W  = SUM_W - DROP;

  logic signed [SUM_W-1:0] sum;
  logic        [HI_W-1:0]  hi;
  logic                    ovf_pos, ovf_neg;
  logic signed [KEEP-1:0]  kept;

  assign sum = $signed({din[IN_W-1], din}) + $signed({{(SUM_W-DROP){1'b0}}, radd});
  assign hi  = sum[SUM_W-1:DROP];

  assign ovf_pos = !hi[HI_W-1] &&  (|hi[HI_W-2:KEEP-1]);
  assign ovf_neg =  hi[HI_W-1] && !(&hi[HI_W-2:KEEP-1]);

  always_comb begin
    if (ovf_pos)      kept = {1'b0, {(KEEP-1){1'b1}}};
    else if (ovf_neg) kept = {1'b1, {(KEEP-1){1'b0}}};
    else              kept = hi[KEEP-1:0];
  end

  assign q = OUT_W'(kept);
endmodule

// File: rtl/word_rounder.sv
module word_rounder #(
  parameter int GUARD_W = 2,
  parameter int FRAC_W  = 32,
  parameter int LONG_W  = 24,
  parameter int SHORT_W = 20,
  parameter int LFSR_W  = 23,
  parameter int LFSR_TAP = 18,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 23'h4F1BD3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  input  logic [GUARD_W+FRAC_W-1:0]   in_sample,
  input  logic                        len_sel,
  input  logic                        dith_en,
  output logic                        out_valid,
  output logic [LONG_W-1:0]           out_sample
);
  import rounder_pkg::*;

  localparam int IN_W    = GUARD_W + FRAC_W;
  localparam int DROP_L  = FRAC_W - LONG_W;
  localparam int DROP_S  = FRAC_W - SHORT_W;
  localparam int DITH_W  = (DROP_S > DROP_L) ? DROP_S : DROP_L;

  logic [DITH_W-1:0] dith_bits;
  logic [LONG_W-1:0] cand [2];
  len_e              len_mode;

  assign len_mode = len_e'(len_sel);

  dither_lfsr #(
    .W(LFSR_W), .TAP(LFSR_TAP), .SEED(LFSR_SEED), .DOUT_W(DITH_W)
  ) u_lfsr (
    .clk(clk), .rst(rst), .adv(in_valid), .dout(dith_bits)
  );

  for (genvar g = 0; g < 2; g++) begin : g_len
    localparam int DROP = (g == 1) ? DROP_L : DROP_S;
    localparam int KEEP = (g == 1) ? LONG_W : SHORT_W;
    localparam logic [DROP-1:0] HALF = DROP'(1) << half_lsb_exp(DROP);
    logic [DROP-1:0] radd;

    assign radd = dith_en ? dith_bits[DROP-1:0] : HALF;

    round_sat #(.IN_W(IN_W), .DROP(DROP), .KEEP(KEEP), .OUT_W(LONG_W)) u_rs (
      .din(in_sample), .radd(radd), .q(cand[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid)
        out_sample <= (len_mode == LEN_LONG) ? cand[1] : cand[0];
    end
  end

  AST_LAT_HIGH: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);  // R1
  AST_LAT_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_sample)));  // R1
  AST_SEXT_SHORT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !len_sel) |=> (out_sample[LONG_W-1:SHORT_W] == {(LONG_W-SHORT_W){out_sample[SHORT_W-1]}}));  // R3
  AST_POS_NOT_NEG: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_sample[IN_W-1]) |=> !out_sample[LONG_W-1]);  // R7
endmodule

// File: tb/word_rounder_bench.sv
module word_rounder_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [33:0] in_sample = '0;
  logic        len_sel = 1'b0;
  logic        dith_en = 1'b1;
  logic        out_valid;
  logic [23:0] out_sample;

  int  n_vec = 0;
  int  n_bad = 0;
  bit  done  = 0;

  logic        exp_v   = 1'b0;
  logic [23:0] exp_s   = '0;
  string       exp_tag = "R2";
  int unsigned lfsr_m  = 23'h4F1BD3;

  always #5 clk = ~clk;

  word_rounder u_word_rounder (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .len_sel(len_sel), .dith_en(dith_en),
    .out_valid(out_valid), .out_sample(out_sample)
  );

  function automatic logic [23:0] ref_word(input logic signed [33:0] v,
                                           input bit wide, input bit dith,
                                           input int unsigned st);
    longint x, r, y, mx, mn;
    int drop, keep;
    x    = v;
    drop = wide ? 8 : 12;
    keep = wide ? 24 : 20;
    r    = dith ? longint'(st & ((1 << drop) - 1)) : (longint'(1) << (drop - 1));
    y    = (x + r) >>> drop;
    mx   = (longint'(1) << (keep - 1)) - 1;
    mn   = -(longint'(1) << (keep - 1));
    if (y > mx) y = mx;
    if (y < mn) y = mn;
    return y[23:0];
  endfunction

  function automatic int unsigned lfsr_next(input int unsigned s);
    return ((s << 1) | (((s >> 22) ^ (s >> 17)) & 1)) & 32'h7FFFFF;
  endfunction

  // Compare what the design shows now, then drive the next cycle's inputs.
  task automatic step(input bit r, input bit v, input logic [33:0] x,
                      input bit wide, input bit dith, input string tag);
    @(negedge clk);
    n_vec++;
    if (out_valid !== exp_v || out_sample !== exp_s) begin
      n_bad++;
      $display("FAIL %s: valid=%0b word=%06h expected valid=%0b word=%06h",
               exp_tag, out_valid, out_sample, exp_v, exp_s);
    end
    rst = r; in_valid = v; in_sample = x; len_sel = wide; dith_en = dith;
    exp_tag = tag;
    if (r) begin
      exp_v = 1'b0; exp_s = '0; lfsr_m = 23'h4F1BD3;
    end else begin
      exp_v = v;
      if (v) begin
        exp_s  = ref_word(x, wide, dith, lfsr_m);
        lfsr_m = lfsr_next(lfsr_m);
      end
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    // R2: reset state
    step(1, 1, 34'h0_7FFF_FFFF, 1, 0, "R2");
    step(1, 0, '0, 0, 1, "R2");
    step(0, 0, '0, 0, 1, "R2");
    step(0, 0, '0, 0, 1, "R1");
    // R4 / R3: plain rounding around half LSB, 24-bit mode
    step(0, 1, 34'h0_0000_0080, 1, 0, "R4");   // -> 1
    step(0, 1, 34'h0_0000_007F, 1, 0, "R4");   // -> 0
    step(0, 1, -34'sh81, 1, 0, "R4");          // -> -1
    step(0, 1, -34'sh80, 1, 0, "R4");          // -> 0
    step(0, 0, '0, 1, 0, "R1");
    step(0, 1, 34'h0_1234_5680, 1, 0, "R3");
    // 20-bit mode
    step(0, 1, 34'h0_0000_0800, 0, 0, "R3");   // -> 1
    step(0, 1, 34'h0_0000_07FF, 0, 0, "R4");
    step(0, 1, -34'sh801, 0, 0, "R3");         // -> F FFFFF sign ext
    step(0, 1, 34'h0_8765_4321, 0, 0, "R3");
    // R7: positive saturation caused by rounding and by headroom
    step(0, 1, 34'h0_7FFF_FF80, 1, 0, "R7");
    step(0, 1, 34'h0_7FFF_FF7F, 1, 0, "R7");
    step(0, 1, 34'h0_7FFF_F800, 0, 0, "R7");
    step(0, 1, 34'h1_0000_0000, 1, 1, "R7");
    step(0, 1, 34'h1_FFFF_FFFF, 0, 0, "R7");
    // R8: negative saturation from headroom
    step(0, 1, 34'h2_0000_0000, 1, 0, "R8");
    step(0, 1, 34'h2_0000_0000, 0, 1, "R8");
    step(0, 1, 34'h3_7FFF_FFFF, 1, 0, "R8");
    step(0, 1, 34'h3_8000_0000, 0, 0, "R8");
    step(0, 0, '0, 0, 0, "R1");
    // R5 / R6: dithered runs with gaps and mixed modes
    for (int i = 0; i < 3000; i++) begin
      logic [33:0] xv;
      bit v, w, d;
      xv = {$urandom, $urandom};
      if ((i % 7) == 0) xv = {{3{xv[33]}}, xv[30:0]};
      v = ($urandom % 4) != 0;
      w = (i / 300) % 2 == 1;
      d = (i / 150) % 3 != 2;
      step(0, v, xv, w, d, d ? "R5" : "R6");
    end
    // R6: reset reseeds the generator
    step(1, 0, '0, 1, 1, "R2");
    for (int i = 0; i < 40; i++)
      step(0, 1, 34'h0_0000_0000, i[0], 1, "R6");
    step(0, 0, '0, 0, 1, "R1");
    step(0, 0, '0, 0, 1, "R1");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule